// File: doc/BRIEF.md
# Interval-Timer Queue Scan Sequencer

This block walks two queues of conversion commands held in an external command memory and, for each command, asks an external converter to sample the selected channel. A command word carries a channel number plus two flags: one that halts the scan after the command, and one that marks the last command of the queue. A single programmable interval timer paces both queues. Each timer expiry is a trigger that either starts a new scan or resumes a halted one. Once triggered, a queue issues its commands back to back until it meets a halting or closing flag.

Each queue runs in one of two ways. With its one-shot enable set, it scans once and the hardware then clears that enable, so software must set it again before the next scan. With its repeat-mode input held high, it rewinds to its first slot after each scan and waits for the next expiry. The converter works on one command at a time, and a done pulse from it is needed before the block moves on. When a trigger finds no queue ready to use it, a sticky overrun flag is set.

Top module: `itq_sequencer`

## Requirements
- R1: While any queue is enabled (one-shot enable bit set, or repeat-mode input high), `tick` pulses for one cycle every PERIOD+1 cycles. After the enable rises from an idle timer, the first pulse comes PERIOD+1 cycles after the clock edge that set the enable. With no queue enabled, the timer holds at zero and `tick` stays low.
- R2: Command word layout: bits [CW-1:0] hold the channel, bit CW is the halt flag, and bit CW+1 is the last-command flag. Queue 1 uses addresses whose top bit is 0, and queue 2 uses addresses whose top bit is 1. Both start at offset 0. A triggered queue issues its commands in address order with no further trigger needed. The first `conv_start` comes 2 cycles after the `tick` cycle that started it.
- R3: `conv_start` is a one-cycle pulse. No new pulse is issued until `conv_done` has answered the previous one.
- R4: After a command with the halt flag completes, the queue shows `q_paused` and issues nothing more until the next `tick`, which resumes it at the following slot.
- R5: After a one-shot queue completes its last command, the hardware clears that queue's bit of `ss_en`, sets its `q_eoq`, clears its `q_active`, and rewinds the queue to its first slot.
- R6: Once the one-shot enable has been cleared by the hardware and no queue is enabled, no `tick` occurs until software pulses `ss_set` again.
- R7: A `tick` that neither starts an idle enabled queue nor resumes a paused one sets `trig_ovr`. The flag stays set until `ovr_clr` is pulsed, and it is never set by a trigger that was used.
- R8: When a queue completes its last command while the other queue is neither running nor paused, the timer restarts from zero, so the next `tick` comes PERIOD cycles after the cycle in which `q_active` is first seen low.
- R9: When a queue completes its last command while the other queue is running or paused, the timer keeps counting, so the `tick` spacing stays PERIOD+1.
- R10: When both queues are running, queue 1 is served first, and `conv_q` names the queue of each strobe (0 for queue 1).
- R11: In repeat mode, completing the last command does not touch `ss_en`. The queue rewinds to its first slot and rescans on the next `tick`.
- R12: After reset, `conv_start`, `tick`, `trig_ovr`, `ss_en` and all the per-queue status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_addr | output | AW | Command memory read address |
| cmd_data | input | CW+2 | Command word read combinationally at `cmd_addr` |
| conv_start | output | 1 | One-cycle request to start a conversion |
| chan_sel | output | CW | Channel of the current conversion |
| conv_q | output | 1 | Queue owning the current conversion (0 = queue 1) |
| conv_done | input | 1 | Converter finished the outstanding conversion |
| period | input | PW | Timer period in clock cycles |
| ss_set | input | 2 | Software pulse that sets each queue's one-shot enable |
| cont_mode | input | 2 | Per-queue repeat-mode enable |
| ovr_clr | input | 1 | Pulse that clears the overrun flag |
| ss_en | output | 2 | One-shot enable bits |
| q_active | output | 2 | Queue running or paused |
| q_paused | output | 2 | Queue halted at a flagged command |
| q_eoq | output | 2 | Queue has completed its last command |
| tick | output | 1 | Timer expiry pulse |
| trig_ovr | output | 1 | Sticky trigger overrun flag |

## Verification
The timer pulse is due PERIOD+1 cycles after the edge that sets an enable. It is due PERIOD cycles after `q_active` is first seen low when the timer restarts, and PERIOD+1 cycles after the previous pulse when it does not. The bench reads a free-running cycle counter on each falling edge and compares these distances exactly. The first strobe after a trigger is checked to come two cycles after the trigger. Later strobes depend on the converter model's latency, so the scoreboard checks only their order and content against the queued expectations, and any strobe with no expectation waiting counts as a miscompare. Status and flag checks are made on the falling edge after the cycle in which the bench sees the state change.

// File: rtl/itq_sequencer.sv
module itq_sequencer #(
  parameter int AW = 4,
  parameter int CW = 4,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] cmd_addr,
  input  logic [CW+1:0] cmd_data,
  output logic          conv_start,
  output logic [CW-1:0] chan_sel,
  output logic          conv_q,
  input  logic          conv_done,
  input  logic [PW-1:0] period,
  input  logic [1:0]    ss_set,
  input  logic [1:0]    cont_mode,
  input  logic          ovr_clr,
  output logic [1:0]    ss_en,
  output logic [1:0]    q_active,
  output logic [1:0]    q_paused,
  output logic [1:0]    q_eoq,
  output logic          tick,
  output logic          trig_ovr
);
  localparam int SW = AW - 1;

  logic [PW-1:0] cnt;
  logic [1:0]    run, pau, en, waiting, take;
  logic [SW-1:0] ptr [2];
  logic          busy, f_pau, f_eoq, gsel, issue, done, other_idle, tmr_rst;

  assign en         = ss_en | cont_mode;
  assign tick       = (|en) && (cnt == period);
  assign waiting    = pau | (en & ~run);
  assign take       = tick ? waiting : 2'b00;
  assign gsel       = ~run[0];
  assign issue      = !busy && (|run);
  assign cmd_addr   = {gsel, ptr[gsel]};
  assign done       = busy && conv_done;
  assign other_idle = !(run[~conv_q] || pau[~conv_q]);
  assign tmr_rst    = done && f_eoq && other_idle;
  assign q_active   = run | pau;
  assign q_paused   = pau;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (!(|en) || tick || tmr_rst) cnt <= '0;
    else cnt <= cnt + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      busy       <= 1'b0;
      chan_sel   <= '0;
      conv_q     <= 1'b0;
      f_pau      <= 1'b0;
      f_eoq      <= 1'b0;
    end else begin
      conv_start <= issue;
      if (issue) begin
        busy     <= 1'b1;
        chan_sel <= cmd_data[CW-1:0];
        conv_q   <= gsel;
        f_pau    <= cmd_data[CW];
        f_eoq    <= cmd_data[CW+1];
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= '0;
      pau      <= '0;
      q_eoq    <= '0;
      ss_en    <= '0;
      ptr[0]   <= '0;
      ptr[1]   <= '0;
      trig_ovr <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (take[i]) begin
          run[i] <= 1'b1;
          pau[i] <= 1'b0;
          if (!pau[i]) q_eoq[i] <= 1'b0;
        end
        if (done && conv_q == 1'(i)) begin
          if (f_eoq) begin
            run[i]   <= 1'b0;
            ptr[i]   <= '0;
            q_eoq[i] <= 1'b1;
            if (!cont_mode[i]) ss_en[i] <= 1'b0;
          end else begin
            ptr[i] <= ptr[i] + SW'(1);
            if (f_pau) begin
              run[i] <= 1'b0;
              pau[i] <= 1'b1;
            end
          end
        end
        if (ss_set[i]) ss_en[i] <= 1'b1;
      end
      if (tick && !(|waiting)) trig_ovr <= 1'b1;
      else if (ovr_clr) trig_ovr <= 1'b0;
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> !conv_start); // R3
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R3
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q_paused[0] && !tick) |=> q_paused[0]); // R4
  AST_SS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && f_eoq && !cont_mode[conv_q] && !ss_set[conv_q]) |=> !ss_en[conv_q]); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_ovr && !ovr_clr) |=> trig_ovr); // R7
  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_en == 2'b00 && cont_mode == 2'b00) |-> !tick); // R6
endmodule

// File: tb/itq_sequencer_tb.sv
module itq_sequencer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cmd_addr;
  logic [5:0] cmd_data;
  logic       conv_start, conv_q, conv_done = 1'b0;
  logic [3:0] chan_sel;
  logic [7:0] period = 8'd20;
  logic [1:0] ss_set = 2'b00, cont_mode = 2'b00;
  logic       ovr_clr = 1'b0;
  logic [1:0] ss_en, q_active, q_paused, q_eoq;
  logic       tick, trig_ovr;

  logic [5:0] mem [16];
  logic [4:0] exp_q [$];
  int cyc = 0, vectors = 0, fails = 0, dly = 0;

  always #5 clk = ~clk;
  assign cmd_data = mem[cmd_addr];

  itq_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .conv_start(conv_start), .chan_sel(chan_sel), .conv_q(conv_q),
    .conv_done(conv_done), .period(period), .ss_set(ss_set),
    .cont_mode(cont_mode), .ovr_clr(ovr_clr), .ss_en(ss_en),
    .q_active(q_active), .q_paused(q_paused), .q_eoq(q_eoq),
    .tick(tick), .trig_ovr(trig_ovr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic q, input logic [3:0] ch);
    exp_q.push_back({q, ch});
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    conv_done = (dly == 1);
    if (dly > 0) dly--;
    if (conv_start) dly = 2;
  end

  always @(negedge clk) begin
    if (rst_n && conv_start) begin
      if (exp_q.size() == 0) chk("R3 unexpected strobe", {conv_q, chan_sel}, 32'h7fff);
      else begin
        logic [4:0] e;
        e = exp_q.pop_front();
        chk("R2 R10 strobe queue/channel", {conv_q, chan_sel}, e);
      end
    end
  end

  task automatic wait_tick(output int t);
    do @(negedge clk); while (!tick);
    t = cyc;
  endtask

  task automatic wait_act(input int idx, input logic val);
    do @(negedge clk); while (q_active[idx] !== val);
  endtask

  task automatic pulse_ss(input logic [1:0] v, output int c);
    @(negedge clk);
    ss_set = v;
    c = cyc;
    @(negedge clk);
    ss_set = 2'b00;
  endtask

  initial begin
    int c, t, t1, f, n;
    for (int i = 0; i < 16; i++) mem[i] = 6'd0;
    mem[0] = {2'b00, 4'd3};
    mem[1] = {2'b01, 4'd5};
    mem[2] = {2'b10, 4'd7};
    mem[8] = {2'b00, 4'd9};
    mem[9] = {2'b10, 4'd10};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 conv_start", conv_start, 0);
    chk("R12 tick", tick, 0);
    chk("R12 trig_ovr", trig_ovr, 0);
    chk("R12 ss_en", ss_en, 0);
    chk("R12 status", {q_active, q_paused, q_eoq}, 0);

    period = 8'd20;
    push(0, 3); push(0, 5);
    pulse_ss(2'b01, c);
    wait_tick(t);
    chk("R1 first tick spacing", t, c + 1 + 20);
    do @(negedge clk); while (!conv_start);
    chk("R2 first strobe delay", cyc, t + 2);
    do @(negedge clk); while (!q_paused[0]);
    chk("R4 paused still active", q_active[0], 1);
    push(0, 7);
    wait_tick(t);
    wait_act(0, 1'b0);
    chk("R5 ss_en cleared", ss_en[0], 0);
    chk("R5 eoq status", q_eoq[0], 1);
    chk("R4 pause released", q_paused[0], 0);
    chk("R7 no false overrun", trig_ovr, 0);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tick) n++;
    end
    chk("R6 timer idle", n, 0);

    period = 8'd1;
    push(0, 3); push(0, 5); push(0, 7);
    pulse_ss(2'b01, c);
    wait_act(0, 1'b1);
    wait_act(0, 1'b0);
    chk("R7 overrun set", trig_ovr, 1);
    repeat (5) @(negedge clk);
    chk("R7 overrun sticky", trig_ovr, 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk("R7 overrun cleared", trig_ovr, 0);

    period = 8'd30;
    push(1, 9); push(1, 10);
    @(negedge clk);
    cont_mode = 2'b10;
    wait_act(1, 1'b1);
    wait_act(1, 1'b0);
    f = cyc;
    chk("R11 ss_en untouched", ss_en, 0);
    chk("R11 eoq status", q_eoq[1], 1);
    push(1, 9); push(1, 10);
    wait_tick(t);
    chk("R8 timer restart", t, f + 30);
    wait_act(1, 1'b1);
    wait_act(1, 1'b0);
    cont_mode = 2'b00;
    repeat (40) @(negedge clk);

    period = 8'd40;
    push(0, 3); push(0, 5); push(1, 9); push(1, 10);
    @(negedge clk);
    cont_mode = 2'b10;
    ss_set = 2'b01;
    @(negedge clk);
    ss_set = 2'b00;
    wait_tick(t1);
    wait_act(1, 1'b1);
    wait_act(1, 1'b0);
    chk("R9 q1 held paused", q_paused[0], 1);
    push(0, 7); push(1, 9); push(1, 10);
    wait_tick(t);
    chk("R9 no restart while other paused", t, t1 + 41);
    wait_act(1, 1'b1);
    wait_act(1, 1'b0);
    f = cyc;
    chk("R9 both idle", q_active, 0);
    push(1, 9); push(1, 10);
    wait_tick(t);
    chk("R9 restart after both done", t, f + 40);
    wait_act(1, 1'b1);
    wait_act(1, 1'b0);
    cont_mode = 2'b00;
    repeat (20) @(negedge clk);
    chk("R2 all expected strobes seen", exp_q.size(), 0);
    chk("R7 no overrun in paced runs", trig_ovr, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule